// File: doc/BRIEF.md
# Capability Memory Access Checker

This block sits between the address-generation stage and the data memory of a capability-aware core. It validates a single capability-width (one granule, eight bytes by default) load or store against the authorising capability. That capability supplies the address, bounds, tag, sealed state and permission bits. The block reports either a fault with a cause code or an accepted access with its effective address.

For stores, it computes the tag to be written alongside the stored capability. A locally-scoped value written through an authority that may not store local capabilities loses its tag, and no fault is raised. For loads, it takes the capability returned from memory and weakens it according to the authority's permissions. It also applies a revocation lookup result supplied for the loaded capability's base. It then presents the tag and permissions to be written back to the register file.

Each request is accepted on a cycle with `req_valid` high. Its result appears on the registered outputs one cycle later, qualified by `rsp_valid`. Requests may be issued back to back.

Top module: `cap_access_checker`

## Requirements
- R1: Each cycle with `req_valid` high produces exactly one cycle of `rsp_valid` on the following cycle, carrying that request's result. `rsp_valid` is low while reset is held and in any cycle that follows a cycle without a request.
- R2: `rsp_addr` equals `auth_addr + req_offset`, truncated to ADDR_W bits so that the sum wraps.
- R3: Faults are reported with `rsp_fault` = 1 in first-match order. The capability-class codes (`rsp_cap_class` = 1) are: untagged authority 1; sealed authority 2; load without the load permission 3, or store without the store permission 4; the bounds check; misalignment. Without a fault, `rsp_fault`, `rsp_cap_class` and `rsp_code` are all 0.
- R4: A store whose stored value is tagged, through an authority lacking the capability load/store permission (bit 6), faults with code 5. This check follows the store-permission check and precedes the bounds check.
- R5: The access is in bounds only when `rsp_addr >= auth_base` and `rsp_addr + 2**GRAN_LOG2 <= auth_top`. `auth_top` is one bit wider than an address so that it can reach the top of the address space. Otherwise the access faults with capability code 6.
- R6: A bounds-clean access whose address is not a multiple of 2**GRAN_LOG2 faults with `rsp_cap_class` = 0. The code is 4 for a load and 6 for a store.
- R7: A store through an authority without the store-local permission (bit 4) writes tag 0 when the stored value lacks its global bit or is a backward sentry, and raises no fault. Otherwise the stored tag passes through.
- R8: `rsp_wr_en` is 1 only for a store with no fault. `rsp_wr_tag` is 0 whenever `rsp_wr_en` is 0.
- R9: On a tagged load through an authority without load-global (bit 1), the result loses global (bit 0) and load-global (bit 1).
- R10: On a tagged, unsealed load through an authority without load-mutable (bit 3), the result loses store (bit 2) and load-mutable (bit 3). A sealed loaded value keeps them.
- R11: A load through an authority without the capability load/store permission (bit 6) returns `rsp_ld_tag` = 0.
- R12: A tagged loaded value with none of seal (bit 7), unseal (bit 8) or user-0 (bit 9) returns tag 0 when `ld_revoked` is 1. With any of those bits set, the revocation result has no effect.
- R13: An untagged loaded value returns its permissions unchanged and tag 0. A faulting request or a store returns `rsp_ld_tag` = 0 and `rsp_ld_perms` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present this cycle |
| req_is_store | input | 1 | 1 = store, 0 = load |
| auth_tag | input | 1 | Authorising capability tag |
| auth_sealed | input | 1 | Authorising capability is sealed |
| auth_perms | input | 12 | Authorising capability permission bits |
| auth_addr | input | ADDR_W | Authorising capability address |
| auth_base | input | ADDR_W | Lower bound (inclusive) |
| auth_top | input | ADDR_W+1 | Upper bound (exclusive) |
| req_offset | input | ADDR_W | Immediate offset |
| st_tag | input | 1 | Tag of the value being stored |
| st_global | input | 1 | Stored value carries the global permission |
| st_bwd_sentry | input | 1 | Stored value is a backward sentry |
| ld_tag | input | 1 | Tag of the value returned by memory |
| ld_perms | input | 12 | Permissions of the value returned by memory |
| ld_sealed | input | 1 | Loaded value is sealed |
| ld_revoked | input | 1 | Revocation lookup for the loaded value's base |
| rsp_valid | output | 1 | Result valid |
| rsp_fault | output | 1 | Access faulted |
| rsp_cap_class | output | 1 | 1 = capability fault code, 0 = address-misaligned code |
| rsp_code | output | 5 | Fault code |
| rsp_addr | output | ADDR_W | Effective address |
| rsp_wr_en | output | 1 | Store may proceed |
| rsp_wr_tag | output | 1 | Tag to write with the stored value |
| rsp_ld_tag | output | 1 | Tag for the loaded value |
| rsp_ld_perms | output | 12 | Attenuated permissions for the loaded value |

## Verification
The bench builds the block with ADDR_W = 16 and GRAN_LOG2 = 3. The narrow address brings wrap-around of the address sum, and a top bound of exactly 2**16, within reach of short constants. The eight-byte granule keeps the last in-bounds slot, a slot one byte past it, and misaligned addresses inside bounds distinct from one another. This separates the bounds check from the alignment check.

// File: rtl/cap_chk_pkg.sv
package cap_chk_pkg;

  localparam int PERM_W = 12;

  // permission bit positions
  localparam int P_GLOBAL    = 0;
  localparam int P_LDGLOBAL  = 1;
  localparam int P_STORE     = 2;
  localparam int P_LDMUTABLE = 3;
  localparam int P_STLOCAL   = 4;
  localparam int P_LOAD      = 5;
  localparam int P_LSCAP     = 6;
  localparam int P_SEAL      = 7;
  localparam int P_UNSEAL    = 8;
  localparam int P_USER0     = 9;

  localparam int CODE_W = 5;

  // capability-class codes
  localparam logic [CODE_W-1:0] CX_NONE     = 5'd0;
  localparam logic [CODE_W-1:0] CX_TAG      = 5'd1;
  localparam logic [CODE_W-1:0] CX_SEAL     = 5'd2;
  localparam logic [CODE_W-1:0] CX_LDPERM   = 5'd3;
  localparam logic [CODE_W-1:0] CX_STPERM   = 5'd4;
  localparam logic [CODE_W-1:0] CX_STCAP    = 5'd5;
  localparam logic [CODE_W-1:0] CX_BOUNDS   = 5'd6;
  // address-class codes
  localparam logic [CODE_W-1:0] AX_LD_ALIGN = 5'd4;
  localparam logic [CODE_W-1:0] AX_ST_ALIGN = 5'd6;

  typedef struct packed {
    logic              fault;
    logic              cap_class;
    logic [CODE_W-1:0] code;
  } chk_result_t;

endpackage

// File: rtl/cap_chk_rst_sync.sv
module cap_chk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cap_chk_gate.sv
module cap_chk_gate
  import cap_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              is_store,
  input  logic              auth_tag,
  input  logic              auth_sealed,
  input  logic              perm_load,
  input  logic              perm_store,
  input  logic              perm_lscap,
  input  logic [ADDR_W-1:0] auth_addr,
  input  logic [ADDR_W-1:0] auth_base,
  input  logic [ADDR_W:0]   auth_top,
  input  logic [ADDR_W-1:0] offset,
  input  logic              st_tag,
  output logic [ADDR_W-1:0] eff_addr,
  output chk_result_t       result
);
  localparam logic [ADDR_W:0] ACCESS_BYTES = {{ADDR_W{1'b0}}, 1'b1} << GRAN_LOG2;

  logic [ADDR_W:0] end_addr;
  logic            in_bounds;
  logic            misaligned;
  logic            access_perm;

  always_comb begin
    eff_addr    = auth_addr + offset;
    end_addr    = {1'b0, eff_addr} + ACCESS_BYTES;
    in_bounds   = (eff_addr >= auth_base) && (end_addr <= auth_top);
    misaligned  = |eff_addr[GRAN_LOG2-1:0];
    access_perm = is_store ? perm_store : perm_load;

    result = '{fault: 1'b0, cap_class: 1'b0, code: CX_NONE};
    if (!auth_tag) begin
      result = '{fault: 1'b1, cap_class: 1'b1, code: CX_TAG};
    end else if (auth_sealed) begin
      result = '{fault: 1'b1, cap_class: 1'b1, code: CX_SEAL};
    end else if (!access_perm) begin
      result = '{fault: 1'b1, cap_class: 1'b1,
                 code: is_store ? CX_STPERM : CX_LDPERM};
    end else if (is_store && st_tag && !perm_lscap) begin
      result = '{fault: 1'b1, cap_class: 1'b1, code: CX_STCAP};
    end else if (!in_bounds) begin
      result = '{fault: 1'b1, cap_class: 1'b1, code: CX_BOUNDS};
    end else if (misaligned) begin
      result = '{fault: 1'b1, cap_class: 1'b0,
                 code: is_store ? AX_ST_ALIGN : AX_LD_ALIGN};
    end
  end
endmodule

// File: rtl/cap_chk_store_tag.sv
module cap_chk_store_tag (
  input  logic perm_stlocal,
  input  logic st_tag,
  input  logic st_global,
  input  logic st_bwd_sentry,
  output logic wr_tag
);
  logic local_value;

  always_comb begin
    local_value = !st_global || st_bwd_sentry;
    wr_tag      = st_tag && !(!perm_stlocal && local_value);
  end
endmodule

// File: rtl/cap_chk_load_atten.sv
module cap_chk_load_atten
  import cap_chk_pkg::*;
(
  input  logic              perm_ldglobal,
  input  logic              perm_ldmutable,
  input  logic              perm_lscap,
  input  logic              ld_tag,
  input  logic [PERM_W-1:0] ld_perms,
  input  logic              ld_sealed,
  input  logic              ld_revoked,
  output logic              out_tag,
  output logic [PERM_W-1:0] out_perms
);
  logic sealing_kind;

  always_comb begin
    out_perms = ld_perms;
    out_tag   = ld_tag;
    if (ld_tag) begin
      if (!perm_ldglobal) begin
        out_perms[P_GLOBAL]   = 1'b0;
        out_perms[P_LDGLOBAL] = 1'b0;
      end
      if (!ld_sealed && !perm_ldmutable) begin
        out_perms[P_STORE]     = 1'b0;
        out_perms[P_LDMUTABLE] = 1'b0;
      end
      if (!perm_lscap) out_tag = 1'b0;
    end
    sealing_kind = out_perms[P_SEAL] | out_perms[P_UNSEAL] | out_perms[P_USER0];
    if (out_tag && !sealing_kind && ld_revoked) out_tag = 1'b0;
  end
endmodule

// File: rtl/cap_access_checker.sv
module cap_access_checker
  import cap_chk_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_is_store,
  input  logic              auth_tag,
  input  logic              auth_sealed,
  input  logic [11:0]       auth_perms,
  input  logic [ADDR_W-1:0] auth_addr,
  input  logic [ADDR_W-1:0] auth_base,
  input  logic [ADDR_W:0]   auth_top,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic              st_tag,
  input  logic              st_global,
  input  logic              st_bwd_sentry,
  input  logic              ld_tag,
  input  logic [11:0]       ld_perms,
  input  logic              ld_sealed,
  input  logic              ld_revoked,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic              rsp_cap_class,
  output logic [4:0]        rsp_code,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              rsp_wr_en,
  output logic              rsp_wr_tag,
  output logic              rsp_ld_tag,
  output logic [11:0]       rsp_ld_perms
);
  typedef struct packed {
    chk_result_t       res;
    logic [ADDR_W-1:0] addr;
    logic              wr_en;
    logic              wr_tag;
    logic              ld_tag;
    logic [PERM_W-1:0] ld_perms;
  } rsp_t;

  logic              rst_sync_n;
  logic [ADDR_W-1:0] eff_addr;
  chk_result_t       chk_res;
  logic              st_tag_out;
  logic              ld_tag_out;
  logic [PERM_W-1:0] ld_perms_out;
  logic              unused_perm_bits;
  rsp_t              rsp_d, rsp_q;
  logic              valid_d, valid_q;

  assign unused_perm_bits = ^{auth_perms[11:7], auth_perms[P_GLOBAL]};

  cap_chk_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cap_chk_gate #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) i_gate (
    .is_store    (req_is_store),
    .auth_tag    (auth_tag),
    .auth_sealed (auth_sealed),
    .perm_load   (auth_perms[P_LOAD]),
    .perm_store  (auth_perms[P_STORE]),
    .perm_lscap  (auth_perms[P_LSCAP]),
    .auth_addr   (auth_addr),
    .auth_base   (auth_base),
    .auth_top    (auth_top),
    .offset      (req_offset),
    .st_tag      (st_tag),
    .eff_addr    (eff_addr),
    .result      (chk_res)
  );

  cap_chk_store_tag i_store_tag (
    .perm_stlocal  (auth_perms[P_STLOCAL]),
    .st_tag        (st_tag),
    .st_global     (st_global),
    .st_bwd_sentry (st_bwd_sentry),
    .wr_tag        (st_tag_out)
  );

  cap_chk_load_atten i_load_atten (
    .perm_ldglobal  (auth_perms[P_LDGLOBAL]),
    .perm_ldmutable (auth_perms[P_LDMUTABLE]),
    .perm_lscap     (auth_perms[P_LSCAP]),
    .ld_tag         (ld_tag),
    .ld_perms       (ld_perms),
    .ld_sealed      (ld_sealed),
    .ld_revoked     (ld_revoked),
    .out_tag        (ld_tag_out),
    .out_perms      (ld_perms_out)
  );

  // next state
  always_comb begin
    logic ld_ok;
    valid_d        = req_valid;
    ld_ok          = !req_is_store && !chk_res.fault;
    rsp_d.res      = chk_res;
    rsp_d.addr     = eff_addr;
    rsp_d.wr_en    = req_is_store && !chk_res.fault;
    rsp_d.wr_tag   = rsp_d.wr_en && st_tag_out;
    rsp_d.ld_tag   = ld_ok && ld_tag_out;
    rsp_d.ld_perms = ld_ok ? ld_perms_out : '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) valid_q <= 1'b0;
    else             valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (req_valid) rsp_q <= rsp_d;
  end

  assign rsp_valid     = valid_q;
  assign rsp_fault     = rsp_q.res.fault;
  assign rsp_cap_class = rsp_q.res.cap_class;
  assign rsp_code      = rsp_q.res.code;
  assign rsp_addr      = rsp_q.addr;
  assign rsp_wr_en     = rsp_q.wr_en;
  assign rsp_wr_tag    = rsp_q.wr_tag;
  assign rsp_ld_tag    = rsp_q.ld_tag;
  assign rsp_ld_perms  = rsp_q.ld_perms;

  // R1: one response per request, on the next cycle
  a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  // R3: a fault always carries a nonzero code
  a_r3_fault_has_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_fault) |-> (rsp_code != CX_NONE));
  // R6: address-class faults use only the two misalignment codes
  a_r6_misalign_codes: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_fault && !rsp_cap_class) |->
      (rsp_code == AX_LD_ALIGN || rsp_code == AX_ST_ALIGN));
  // R7: backward sentry stored without store-local loses its tag
  a_r7_local_strip: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_is_store && !auth_perms[P_STLOCAL] && st_bwd_sentry) |=> !rsp_wr_tag);
  // R8: a faulting access never writes
  a_r8_no_write_on_fault: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && rsp_fault) |-> !rsp_wr_en);
  // R11: no capability load/store permission means no loaded tag
  a_r11_lscap_clears_tag: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !auth_perms[P_LSCAP]) |=> !rsp_ld_tag);
  // R13: loaded permissions never gain bits
  a_r13_perm_subset: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> ((rsp_ld_perms & ~$past(ld_perms)) == '0));
endmodule

// File: tb/test_cap_access_checker.sv
`timescale 1ns/1ps
module test_cap_access_checker;
  localparam int AW = 16;

  typedef struct {
    logic          is_store;
    logic          a_tag;
    logic          a_sealed;
    logic [11:0]   perms;
    logic [AW-1:0] addr;
    logic [AW-1:0] base;
    logic [AW:0]   top;
    logic [AW-1:0] off;
    logic          s_tag;
    logic          s_global;
    logic          s_bwd;
    logic          l_tag;
    logic [11:0]   l_perms;
    logic          l_sealed;
    logic          l_revoked;
  } req_t;

  typedef struct {
    logic          fault;
    logic          cls;
    logic [4:0]    code;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic          wr_tag;
    logic          ld_tag;
    logic [11:0]   ld_perms;
    string         tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_is_store, auth_tag, auth_sealed;
  logic [11:0] auth_perms, ld_perms;
  logic [AW-1:0] auth_addr, auth_base, req_offset;
  logic [AW:0] auth_top;
  logic st_tag, st_global, st_bwd_sentry, ld_tag, ld_sealed, ld_revoked;
  logic rsp_valid, rsp_fault, rsp_cap_class, rsp_wr_en, rsp_wr_tag, rsp_ld_tag;
  logic [4:0] rsp_code;
  logic [AW-1:0] rsp_addr;
  logic [11:0] rsp_ld_perms;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  cap_access_checker #(.ADDR_W(AW), .GRAN_LOG2(3)) i_cap_access_checker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_store(req_is_store),
    .auth_tag(auth_tag), .auth_sealed(auth_sealed), .auth_perms(auth_perms),
    .auth_addr(auth_addr), .auth_base(auth_base), .auth_top(auth_top),
    .req_offset(req_offset), .st_tag(st_tag), .st_global(st_global),
    .st_bwd_sentry(st_bwd_sentry), .ld_tag(ld_tag), .ld_perms(ld_perms),
    .ld_sealed(ld_sealed), .ld_revoked(ld_revoked), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cap_class(rsp_cap_class), .rsp_code(rsp_code),
    .rsp_addr(rsp_addr), .rsp_wr_en(rsp_wr_en), .rsp_wr_tag(rsp_wr_tag),
    .rsp_ld_tag(rsp_ld_tag), .rsp_ld_perms(rsp_ld_perms)
  );

  // reference model from the requirements
  function automatic exp_t predict(req_t r, string tag);
    exp_t e;
    logic [AW:0] last;
    logic [11:0] p;
    logic t, st, ok;
    e.tag = tag;
    e.addr = r.addr + r.off;
    last = {1'b0, e.addr} + 17'd8;
    e.fault = 1; e.cls = 1;
    if (!r.a_tag) e.code = 1;
    else if (r.a_sealed) e.code = 2;
    else if (r.is_store && !r.perms[2]) e.code = 4;
    else if (!r.is_store && !r.perms[5]) e.code = 3;
    else if (r.is_store && r.s_tag && !r.perms[6]) e.code = 5;
    else if (!(e.addr >= r.base && last <= r.top)) e.code = 6;
    else if (e.addr[2:0] != 0) begin e.cls = 0; e.code = r.is_store ? 5'd6 : 5'd4; end
    else begin e.fault = 0; e.cls = 0; e.code = 0; end
    st = r.s_tag;
    if (!r.perms[4] && (!r.s_global || r.s_bwd)) st = 0;
    e.wr_en = r.is_store && !e.fault;
    e.wr_tag = e.wr_en && st;
    p = r.l_perms; t = r.l_tag;
    if (r.l_tag) begin
      if (!r.perms[1]) begin p[0] = 0; p[1] = 0; end
      if (!r.l_sealed && !r.perms[3]) begin p[2] = 0; p[3] = 0; end
      if (!r.perms[6]) t = 0;
    end
    if (t && p[9:7] == 3'b000 && r.l_revoked) t = 0;
    ok = !r.is_store && !e.fault;
    e.ld_tag = ok && t;
    e.ld_perms = ok ? p : 12'h000;
    return e;
  endfunction

  function automatic req_t good_load();
    req_t r;
    r.is_store = 0; r.a_tag = 1; r.a_sealed = 0; r.perms = 12'hFFF;
    r.addr = 16'h1000; r.base = 16'h0F00; r.top = 17'h01100; r.off = 16'h0000;
    r.s_tag = 0; r.s_global = 1; r.s_bwd = 0;
    r.l_tag = 1; r.l_perms = 12'hFFF; r.l_sealed = 0; r.l_revoked = 0;
    return r;
  endfunction

  task automatic send(req_t r, string tag);
    @(negedge clk);
    req_valid = 1; req_is_store = r.is_store; auth_tag = r.a_tag;
    auth_sealed = r.a_sealed; auth_perms = r.perms; auth_addr = r.addr;
    auth_base = r.base; auth_top = r.top; req_offset = r.off;
    st_tag = r.s_tag; st_global = r.s_global; st_bwd_sentry = r.s_bwd;
    ld_tag = r.l_tag; ld_perms = r.l_perms; ld_sealed = r.l_sealed;
    ld_revoked = r.l_revoked;
    sb.push_back(predict(r, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t e;
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response: actual rsp_valid=1 expected 0");
      end else begin
        e = sb.pop_front();
        if ({rsp_fault, rsp_cap_class, rsp_code, rsp_addr, rsp_wr_en, rsp_wr_tag,
             rsp_ld_tag, rsp_ld_perms} !==
            {e.fault, e.cls, e.code, e.addr, e.wr_en, e.wr_tag, e.ld_tag, e.ld_perms}) begin
          errors++;
          $display("FAIL %s: actual f=%0b c=%0b code=%0d a=%h we=%0b wt=%0b lt=%0b lp=%h expected f=%0b c=%0b code=%0d a=%h we=%0b wt=%0b lt=%0b lp=%h",
                   e.tag, rsp_fault, rsp_cap_class, rsp_code, rsp_addr, rsp_wr_en,
                   rsp_wr_tag, rsp_ld_tag, rsp_ld_perms, e.fault, e.cls, e.code,
                   e.addr, e.wr_en, e.wr_tag, e.ld_tag, e.ld_perms);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    req_t r;
    rst_n = 0; req_valid = 0;
    repeat (4) @(negedge clk);
    checks++;
    if (rsp_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset: actual rsp_valid=%0b expected 0", rsp_valid);
    end
    rst_n = 1;
    repeat (4) @(negedge clk);

    // main function
    r = good_load(); send(r, "R2 good load");
    r = good_load(); r.off = 16'h0040; send(r, "R2 offset load");
    r = good_load(); r.is_store = 1; r.s_tag = 1; send(r, "R8 good store");
    // wrap of the address sum, top at 2**16
    r = good_load(); r.addr = 16'hFFF0; r.off = 16'h0018; r.base = 16'h0000; r.top = 17'h10000;
    send(r, "R2 wrap");
    r = good_load(); r.addr = 16'hFFF8; r.base = 16'hFF00; r.top = 17'h10000;
    send(r, "R5 top of space");
    // priority
    r = good_load(); r.a_tag = 0; r.a_sealed = 1; r.perms = 0; r.off = 16'h0801; send(r, "R3 tag first");
    r = good_load(); r.a_sealed = 1; r.perms = 0; r.off = 16'h0801; send(r, "R3 seal second");
    r = good_load(); r.perms[5] = 0; r.off = 16'h0801; send(r, "R3 load perm");
    r = good_load(); r.is_store = 1; r.perms[2] = 0; r.off = 16'h0801; send(r, "R3 store perm");
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.perms[6] = 0; r.off = 16'h0801; send(r, "R4 store cap perm");
    r = good_load(); r.is_store = 1; r.s_tag = 0; r.perms[6] = 0; send(r, "R4 untagged store ok");
    // bounds
    r = good_load(); r.off = 16'h00F8; send(r, "R5 last slot");
    r = good_load(); r.off = 16'h00FC; send(r, "R5 past top");
    r = good_load(); r.addr = 16'h0EF8; send(r, "R5 below base");
    r = good_load(); r.off = 16'h00F9; send(r, "R5 straddle");
    // misalignment
    r = good_load(); r.off = 16'h0004; send(r, "R6 load misalign");
    r = good_load(); r.is_store = 1; r.off = 16'h0002; send(r, "R6 store misalign");
    idle();
    // store tag stripping
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.perms[4] = 0; r.s_global = 0; send(r, "R7 non-global");
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.perms[4] = 0; r.s_bwd = 1; send(r, "R7 bwd sentry");
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.perms[4] = 0; send(r, "R7 global kept");
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.s_global = 0; r.s_bwd = 1; send(r, "R7 local allowed");
    r = good_load(); r.is_store = 1; r.s_tag = 1; r.off = 16'h0003; send(r, "R8 fault no write");
    // load attenuation
    r = good_load(); r.perms[1] = 0; send(r, "R9 load global");
    r = good_load(); r.perms[3] = 0; send(r, "R10 load mutable unsealed");
    r = good_load(); r.perms[3] = 0; r.l_sealed = 1; send(r, "R10 load mutable sealed");
    r = good_load(); r.perms[6] = 0; send(r, "R11 lscap");
    r = good_load(); r.l_perms = 12'h07F; r.l_revoked = 1; send(r, "R12 revoked");
    r = good_load(); r.l_perms = 12'h27F; r.l_revoked = 1; send(r, "R12 user0 exempt");
    r = good_load(); r.l_perms = 12'h07F; r.l_revoked = 0; send(r, "R12 not revoked");
    r = good_load(); r.l_tag = 0; r.perms = 12'hFE1 | 12'h020; r.l_perms = 12'h0AB; send(r, "R13 untagged");
    r = good_load(); r.a_sealed = 1; send(r, "R13 fault zeroes load");
    r = good_load(); r.is_store = 1; send(r, "R13 store zeroes load");
    idle();
    repeat (4) @(negedge clk);
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R1 missing responses: actual %0d pending expected 0", sb.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule